// File: doc/BRIEF.md
# Completion Queue Posting Engine

This block closes the loop on an I/O command once its data has been moved. The data-transfer engine hands it a done notice naming a completion queue, the command identifier, a status code, the submission-queue identifier and the current submission-queue head. The engine formats a four-dword completion entry, writes it dword by dword into the chosen completion queue in host memory, waits until every dword write has been acknowledged, and then requests a message-signalled interrupt for that queue.

Each completion queue keeps its own tail slot, phase tag and host-written head. The host frees entries by writing a new head value to that queue's head doorbell, which the block accepts at any time. When a queue has no free slot, the block withholds its ready signal for notices aimed at that queue. Notices are served strictly one at a time in arrival order, so a notice for a full queue holds back all notices behind it.

Queue `q` occupies `DEPTH` consecutive 16-byte slots starting at `BASE_ADDR + q*DEPTH*16`. `NQ` and `DEPTH` must be powers of two.

Top module: `cpe_engine`

## Requirements
- R1: After reset every queue has tail 0, head 0 and phase tag 1; `doneReady` is high while idle with the addressed queue not full, and `wrValid` and `irqValid` are low.
- R2: An entry is written as four single-dword beats in the order dword 0, 1, 2, 3; dwords 0 and 1 are zero, dword 2 is {submission-queue ID in bits 31:16, submission-queue head in bits 15:0}, dword 3 is {status in bits 31:17, phase tag in bit 16, command ID in bits 15:0}.
- R3: Beat `d` of an entry for queue `q` at slot `t` goes to address `BASE_ADDR + q*DEPTH*16 + t*16 + d*4`.
- R4: Each post advances only its own queue's tail by one, wrapping from `DEPTH-1` to 0; that queue's phase tag inverts on each wrap.
- R5: A queue is full when (tail+1) mod `DEPTH` equals its head; `doneReady` is low while the notice's queue is full.
- R6: `irqValid` rises only after four write responses for the current entry have been seen, carries the entry's queue in `irqVector`, and holds with a stable vector until `irqReady`.
- R7: While an entry is being written or its interrupt is pending, `doneReady` is low, so notices are taken one at a time in arrival order.
- R8: A doorbell write changes the head of the addressed queue only, and is accepted in any state.
- R9: `wrValid` holds with stable `wrAddr` and `wrData` until `wrReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| doneValid | input | 1 | Done notice present |
| doneReady | output | 1 | Notice accepted this cycle when high with doneValid |
| doneQid | input | log2(NQ) | Target completion queue |
| doneCid | input | 16 | Command identifier |
| doneSqId | input | 16 | Submission-queue identifier |
| doneSqHead | input | 16 | Submission-queue head |
| doneStatus | input | 15 | Completion status |
| dbValid | input | 1 | Head doorbell write strobe |
| dbQid | input | log2(NQ) | Queue whose doorbell is written |
| dbHead | input | log2(DEPTH) | New head slot |
| wrValid | output | 1 | Host memory write beat valid |
| wrReady | input | 1 | Host memory write beat accepted |
| wrAddr | output | AW | Byte address of the beat |
| wrData | output | 32 | Dword of the entry |
| wrResp | input | 1 | One write acknowledgement |
| irqValid | output | 1 | Interrupt request |
| irqReady | input | 1 | Interrupt request taken |
| irqVector | output | log2(NQ) | Queue that the interrupt announces |

## Verification
The bench builds the engine with four queues of depth four, so a queue fills after three posts and wraps its tail after four, which puts the full stall, the doorbell release and the phase inversion within a few dozen cycles. Four queues let posts for several queues interleave, and a doorbell to one queue can be shown not to free another. Host-side ready and response timing switch between always-ready and a pseudo-random pattern to stretch write stalls and response gaps.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
  localparam int ENTRY_DW  = 4;
  localparam int DW_SEL_W  = 2;
  localparam int ID_W      = 16;
  localparam int STATUS_W  = 15;
  localparam int SLOT_SHIFT = 4;

  typedef struct packed {
    logic latchNotice;
    logic advanceTail;
  } cpeStrobes_t;
endpackage

// File: rtl/cpe_datapath.sv
module cpe_datapath
  import cpe_pkg::*;
#(
  parameter int unsigned NQ = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 'h10_0000,
  parameter int unsigned QID_W = $clog2(NQ),
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  cpeStrobes_t         strobes,
  input  logic [QID_W-1:0]    doneQid,
  input  logic [ID_W-1:0]     doneCid,
  input  logic [ID_W-1:0]     doneSqId,
  input  logic [ID_W-1:0]     doneSqHead,
  input  logic [STATUS_W-1:0] doneStatus,
  input  logic                dbValid,
  input  logic [QID_W-1:0]    dbQid,
  input  logic [PTR_W-1:0]    dbHead,
  input  logic [DW_SEL_W-1:0] dwSel,
  output logic                doneQueueFull,
  output logic [AW-1:0]       wrAddr,
  output logic [31:0]         wrData,
  output logic [QID_W-1:0]    curQid
);
  localparam int unsigned QUEUE_SHIFT = PTR_W + SLOT_SHIFT;

  logic [PTR_W-1:0] tailQ  [NQ];
  logic [PTR_W-1:0] headQ  [NQ];
  logic             phaseQ [NQ];

  logic [ID_W-1:0]     curCid, curSqId, curSqHead;
  logic [STATUS_W-1:0] curStatus;
  logic [PTR_W-1:0]    nextTailSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int q = 0; q < int'(NQ); q++) begin
        tailQ[q]  <= '0;
        headQ[q]  <= '0;
        phaseQ[q] <= 1'b1;
      end
      curQid    <= '0;
      curCid    <= '0;
      curSqId   <= '0;
      curSqHead <= '0;
      curStatus <= '0;
    end else begin
      if (strobes.latchNotice) begin
        curQid    <= doneQid;
        curCid    <= doneCid;
        curSqId   <= doneSqId;
        curSqHead <= doneSqHead;
        curStatus <= doneStatus;
      end
      for (int q = 0; q < int'(NQ); q++) begin
        if (dbValid && dbQid == QID_W'(q)) headQ[q] <= dbHead;
        if (strobes.advanceTail && curQid == QID_W'(q)) begin
          tailQ[q] <= tailQ[q] + 1'b1;
          if (tailQ[q] == PTR_W'(DEPTH - 1)) phaseQ[q] <= ~phaseQ[q];
        end
      end
    end
  end

  assign nextTailSel   = tailQ[doneQid] + 1'b1;
  assign doneQueueFull = (nextTailSel == headQ[doneQid]);

  assign wrAddr = BASE_ADDR
                + (AW'(curQid) << QUEUE_SHIFT)
                + (AW'(tailQ[curQid]) << SLOT_SHIFT)
                + (AW'(dwSel) << 2);

  always_comb begin
    case (dwSel)
      DW_SEL_W'(2): wrData = {curSqId, curSqHead};
      DW_SEL_W'(3): wrData = {curStatus, phaseQ[curQid], curCid};
      default:      wrData = '0;
    endcase
  end
endmodule

// File: rtl/cpe_control.sv
module cpe_control
  import cpe_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                doneValid,
  input  logic                doneQueueFull,
  input  logic                wrReady,
  input  logic                wrResp,
  input  logic                irqReady,
  output logic                doneReady,
  output logic                wrValid,
  output logic                irqValid,
  output logic [DW_SEL_W-1:0] dwSel,
  output cpeStrobes_t         strobes
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_DRAIN, S_IRQ} cpeState_t;

  cpeState_t           state;
  logic [DW_SEL_W-1:0] beatCnt;
  logic [2:0]          respCnt;

  assign doneReady = (state == S_IDLE) && !doneQueueFull;
  assign wrValid   = (state == S_SEND);
  assign irqValid  = (state == S_IRQ);
  assign dwSel     = beatCnt;

  assign strobes.latchNotice = doneValid && doneReady;
  assign strobes.advanceTail = irqValid && irqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      beatCnt <= '0;
      respCnt <= '0;
    end else begin
      if (wrResp && (state == S_SEND || state == S_DRAIN)) respCnt <= respCnt + 1'b1;
      case (state)
        S_IDLE: if (strobes.latchNotice) begin
          state   <= S_SEND;
          beatCnt <= '0;
          respCnt <= '0;
        end
        S_SEND: if (wrReady) begin
          beatCnt <= beatCnt + 1'b1;
          if (beatCnt == DW_SEL_W'(ENTRY_DW - 1)) state <= S_DRAIN;
        end
        S_DRAIN: if (respCnt == 3'(ENTRY_DW)) state <= S_IRQ;
        S_IRQ:   if (irqReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cpe_engine.sv
module cpe_engine
  import cpe_pkg::*;
#(
  parameter int unsigned NQ = 8,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] BASE_ADDR = 'h10_0000
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      doneValid,
  output logic                      doneReady,
  input  logic [$clog2(NQ)-1:0]     doneQid,
  input  logic [15:0]               doneCid,
  input  logic [15:0]               doneSqId,
  input  logic [15:0]               doneSqHead,
  input  logic [14:0]               doneStatus,
  input  logic                      dbValid,
  input  logic [$clog2(NQ)-1:0]     dbQid,
  input  logic [$clog2(DEPTH)-1:0]  dbHead,
  output logic                      wrValid,
  input  logic                      wrReady,
  output logic [AW-1:0]             wrAddr,
  output logic [31:0]               wrData,
  input  logic                      wrResp,
  output logic                      irqValid,
  input  logic                      irqReady,
  output logic [$clog2(NQ)-1:0]     irqVector
);
  cpeStrobes_t         strobes;
  logic                doneQueueFull;
  logic [DW_SEL_W-1:0] dwSel;

  cpe_control u_ctl (
    .clk(clk), .rstN(rstN), .doneValid(doneValid), .doneQueueFull(doneQueueFull),
    .wrReady(wrReady), .wrResp(wrResp), .irqReady(irqReady),
    .doneReady(doneReady), .wrValid(wrValid), .irqValid(irqValid),
    .dwSel(dwSel), .strobes(strobes)
  );

  cpe_datapath #(.NQ(NQ), .DEPTH(DEPTH), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .doneQid(doneQid), .doneCid(doneCid), .doneSqId(doneSqId),
    .doneSqHead(doneSqHead), .doneStatus(doneStatus),
    .dbValid(dbValid), .dbQid(dbQid), .dbHead(dbHead), .dwSel(dwSel),
    .doneQueueFull(doneQueueFull), .wrAddr(wrAddr), .wrData(wrData),
    .curQid(irqVector)
  );
endmodule

// File: rtl/cpe_checker.sv
module cpe_checker #(
  parameter int unsigned NQ = 8,
  parameter int unsigned AW = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  doneReady,
  input logic                  wrValid,
  input logic                  wrReady,
  input logic [AW-1:0]         wrAddr,
  input logic [31:0]           wrData,
  input logic                  wrResp,
  input logic                  irqValid,
  input logic                  irqReady,
  input logic [$clog2(NQ)-1:0] irqVector
);
  logic [2:0] respSeen, beatSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respSeen <= '0;
      beatSeen <= '0;
    end else if (irqValid && irqReady) begin
      respSeen <= '0;
      beatSeen <= '0;
    end else begin
      if (wrResp) respSeen <= respSeen + 1'b1;
      if (wrValid && wrReady) beatSeen <= beatSeen + 1'b1;
    end
  end

  p_irq_after_resp_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (respSeen == 3'd4 && beatSeen == 3'd4));

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !irqReady) |=> (irqValid && $stable(irqVector)));

  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));

  p_single_post_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || irqValid) |-> !doneReady);

  p_beat_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (beatSeen < 3'd4 && !irqValid));
endmodule

bind cpe_engine cpe_checker #(.NQ(NQ), .AW(AW)) u_chk (.*);

// File: tb/tb_cpe_engine.sv
module tb_cpe_engine;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int NQ = 4;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h8000_0000;

  logic clk = 0;
  logic rstN = 0;
  logic doneValid = 0;
  logic [1:0] doneQid = 0;
  logic [15:0] doneCid = 0, doneSqId = 0, doneSqHead = 0;
  logic [14:0] doneStatus = 0;
  logic dbValid = 0;
  logic [1:0] dbQid = 0;
  logic [1:0] dbHead = 0;
  logic wrReady = 0, wrResp = 0, irqReady = 0;
  logic doneReady, wrValid, irqValid;
  logic [31:0] wrAddr, wrData;
  logic [1:0] irqVector;

  cpe_engine #(.NQ(NQ), .DEPTH(DEPTH), .AW(AW), .BASE_ADDR(BASE)) dut (.*);

  always #(HALF) clk = ~clk;

  int nChecks = 0, nFails = 0;
  int mTail[NQ], mHead[NQ], mPhase[NQ];
  bit busy = 0;
  int curQ = 0, respGot = 0;
  logic [31:0] expAddr[$], expData[$];
  int beatsAcc = 0, respSent = 0;
  int hostMode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prevWrStall = 0, prevIrqStall = 0;
  logic [31:0] prevAddr, prevData;
  logic [1:0] prevVec;

  task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit mFull(int q);
    return ((mTail[q] + 1) % DEPTH) == mHead[q];
  endfunction

  // host side: ready and response patterns, driven at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rstN) begin
      wrReady = 0; irqReady = 0; wrResp = 0;
    end else begin
      wrReady  = (hostMode == 0) ? 1'b1 : lfsr[0];
      irqReady = (hostMode == 0) ? 1'b1 : lfsr[3];
      if ((beatsAcc - respSent) > 0 && (hostMode == 0 || lfsr[5])) begin
        wrResp = 1; respSent++;
      end else wrResp = 0;
    end
  end

  // reference model, compared just before each rising edge
  always @(negedge clk) begin
    #(HALF - 1);
    if (rstN) begin
      bit expReady;
      expReady = !busy && !mFull(int'(doneQid));
      check(doneReady == expReady, busy ? "R7" : (mFull(int'(doneQid)) ? "R5" : "R1"),
            32'(doneReady), 32'(expReady));
      if (prevWrStall)
        check(wrValid && wrAddr == prevAddr && wrData == prevData, "R9", wrAddr, prevAddr);
      if (prevIrqStall)
        check(irqValid && irqVector == prevVec, "R6", 32'(irqVector), 32'(prevVec));
      if (wrValid || irqValid) check(busy, "R7", 32'(wrValid), 32'(0));
      if (wrValid && wrReady) begin
        if (expAddr.size() == 0) check(0, "R2", wrAddr, 32'hFFFF_FFFF);
        else begin
          logic [31:0] ea, ed;
          ea = expAddr.pop_front(); ed = expData.pop_front();
          check(wrAddr == ea, "R3", wrAddr, ea);
          check(wrData == ed, "R2", wrData, ed);
          if (ea[3:2] == 2'd3) check(wrData[16] == ed[16], "R4", 32'(wrData[16]), 32'(ed[16]));
        end
        beatsAcc++;
      end
      if (irqValid) check(respGot == 4 && expAddr.size() == 0, "R6", respGot, 4);
      if (irqValid && irqReady) begin
        check(irqVector == 2'(curQ), "R6", 32'(irqVector), curQ);
        busy = 0;
        if (mTail[curQ] == DEPTH - 1) mPhase[curQ] = 1 - mPhase[curQ];
        mTail[curQ] = (mTail[curQ] + 1) % DEPTH;
      end
      if (wrResp) respGot++;
      if (doneValid && expReady) begin
        int q;
        q = int'(doneQid);
        busy = 1; curQ = q; respGot = 0;
        for (int d = 0; d < 4; d++)
          expAddr.push_back(BASE + 32'(q * DEPTH * 16) + 32'(mTail[q] * 16) + 32'(d * 4));
        expData.push_back(32'h0);
        expData.push_back(32'h0);
        expData.push_back({doneSqId, doneSqHead});
        expData.push_back({doneStatus, 1'(mPhase[q]), doneCid});
      end
      if (dbValid) mHead[int'(dbQid)] = int'(dbHead);
      prevWrStall = wrValid && !wrReady;
      prevIrqStall = irqValid && !irqReady;
      prevAddr = wrAddr; prevData = wrData; prevVec = irqVector;
    end
  end

  task automatic driveNotice(int q, int cid, int st, int sqh, int sqid);
    @(negedge clk);
    doneValid = 1; doneQid = 2'(q); doneCid = 16'(cid);
    doneStatus = 15'(st); doneSqHead = 16'(sqh); doneSqId = 16'(sqid);
  endtask

  task automatic waitAccept();
    bit acc = 0;
    while (!acc) begin
      #(HALF - 1);
      acc = doneReady;
      @(negedge clk);
    end
    doneValid = 0;
  endtask

  task automatic send(int q, int cid, int st, int sqh, int sqid);
    driveNotice(q, cid, st, sqh, sqid);
    waitAccept();
  endtask

  task automatic ringDoorbell(int q, int h);
    @(negedge clk);
    dbValid = 1; dbQid = 2'(q); dbHead = 2'(h);
    @(negedge clk);
    dbValid = 0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy || expAddr.size() != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin mTail[q] = 0; mHead[q] = 0; mPhase[q] = 1; end
    repeat (3) @(negedge clk);
    rstN = 1;
    #(HALF - 1);
    check(doneReady == 1'b1, "R1", 32'(doneReady), 1);
    check(wrValid == 1'b0 && irqValid == 1'b0, "R1", 32'({wrValid, irqValid}), 0);

    // single post, always-ready host
    send(0, 16'h1234, 15'h5A5A, 7, 3);
    waitIdle();

    // fill queue 1, pseudo-random host timing
    hostMode = 1;
    for (int i = 0; i < DEPTH - 1; i++) send(1, 16'h0100 + i, 15'h0011 * (i + 1), 20 + i, 1);
    waitIdle();
    driveNotice(1, 16'h0BAD, 15'h7FFF, 9, 1);
    repeat (4) @(negedge clk);
    #(HALF - 1);
    check(doneReady == 1'b0, "R5", 32'(doneReady), 0);
    ringDoorbell(0, 1);
    #(HALF - 1);
    check(doneReady == 1'b0, "R8", 32'(doneReady), 0);
    ringDoorbell(1, 2);
    waitAccept();
    waitIdle();
    // wrapped: next slot 0 with inverted phase
    send(1, 16'hC0DE, 15'h0042, 5, 1);
    waitIdle();
    #(HALF - 1);
    doneQid = 2'd1;
    #1;
    check(doneReady == 1'b0, "R5", 32'(doneReady), 0);
    ringDoorbell(1, 1);
    send(1, 16'hD00D, 15'h1234, 6, 1);
    waitIdle();

    // interleaved queues, keeping each free via doorbells
    for (int i = 0; i < 24; i++) begin
      int q;
      q = (i * 3 + 2) % NQ;
      if (i == 12) hostMode = 0;
      ringDoorbell(q, mTail[q]);
      send(q, 16'h2000 + i * 17, (i * 389) % 32768, i * 5, q + 8);
      if (i % 4 == 3) waitIdle();
    end
    waitIdle();
    repeat (4) @(negedge clk);
    check(expAddr.size() == 0 && !busy, "R6", 32'(expAddr.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule